// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block reads a 4x4 key matrix by energising one row line at a time and looking at the four column lines while that row is active. The column lines are asynchronous to the block's clock, so they pass through a chain of flip-flops before any logic uses them. At the end of each full sweep over the rows, the scanner produces one candidate key code. A debounce stage then compares that candidate with the code it currently reports, and replaces the reported code only once the two have differed for a full debounce interval.

The reported code packs the one-based row number into the upper nibble and the one-based column number into the lower nibble. Row 3, column 2 therefore reads 0x32. The value 0x00 means that no key is held. Each accepted change raises a single-cycle strobe. This covers a new press, a direct move from one key to another, and a release. Downstream logic, such as a character converter or a lock-key toggle, acts on that strobe. The corner position 0x11 is treated like every other key.

Top module: `kpd_scanner`

## Requirements
- R1: `row_drive` is active-high and one-hot. Bit 0 drives row 1. Each row is held for `DWELL` clock cycles, and the rows follow the cycle 1, 2, 3, 4, 1, and so on.
- R2: A reported key has its one-based row number (1 to 4) in bits 7:4 of `key_code` and its one-based column number (1 to 4) in bits 3:0. Column input bit 0 is column 1. For example, row 3 with column 2 gives 0x32.
- R3: `key_code` is 0x00 when no key is reported, and `key_valid` is high exactly when `key_code` is nonzero.
- R4: Column inputs pass through a synchroniser of `SYNC_STAGES` flip-flops (at least 2, default 3). Each row's columns are read on the last cycle of its dwell, so a key in any row and any column is detected.
- R5: A new scan result replaces the reported code only after it has differed from the reported code for `DEBOUNCE` consecutive clock cycles. A press or release shorter than that leaves `key_code` and `key_strobe` unchanged.
- R6: `key_strobe` is high for exactly one cycle each time a change is accepted, and this includes the release to 0x00. `key_code` shows the new value in that same cycle.
- R7: When more than one column is active in one row, the lowest-numbered column is reported.
- R8: When keys are held in more than one row, the key in the lowest-numbered row is reported.
- R9: Row 1, column 1 is reported as 0x11, with a strobe, like any other key.
- R10: A synchronous active-high `rst` puts the scan at row 1, sets `key_code` to 0x00 with `key_valid` and `key_strobe` low, and clears the debounce count.
- R11: A move from one held key directly to another is reported as a single change to the new code, without passing through 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_in | input | COLS | Raw column lines, active high, asynchronous |
| row_drive | output | ROWS | One-hot row select, active high |
| key_code | output | 8 | Debounced key code {row, column}, 0x00 for none |
| key_valid | output | 1 | High while a key is reported |
| key_strobe | output | 1 | One-cycle pulse on each accepted change |

## Verification
The bench looks for the faults most likely to hide in a scanner like this, using a keypad model that closes the matrix from `row_drive`. If the synchroniser delay and the dwell were misaligned, keys in a row would be credited to its neighbour and read back with the wrong row nibble. If the column priority ran the wrong way, a chord within one row would report the highest column. A corner case at 0x11 checks that the code of all-ones indices is not confused with "no key". A short press tests the debouncer: one that accepted early, or counted only from the first glitch, would raise a strobe that should not occur. The bench also catches a strobe wider than one cycle or a missing release strobe, and a direct key-to-key move that slips through 0x00 would raise two strobes instead of one.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   localparam int NIB_W  = 4;
   localparam int CODE_W = 2 * NIB_W;

   typedef logic [CODE_W-1:0] key_code_t;

   // Pack zero-based row/column indices into a one-based {row, col} code.
   function automatic key_code_t pack_code(input int unsigned row_idx,
                                           input int unsigned col_idx);
      return {NIB_W'(row_idx + 1), NIB_W'(col_idx + 1)};
   endfunction
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
   parameter int W      = 4,
   parameter int STAGES = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("kpd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[s] <= '0;
         else     chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/kpd_scan.sv
module kpd_scan
   import kpd_pkg::*;
#(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int DWELL = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [COLS-1:0] col_sync,
   output logic [ROWS-1:0] row_drive,
   output key_code_t       scan_code
);
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

   logic [RW-1:0] row_q;
   logic [DW-1:0] dwell_q;
   logic          found_q;
   key_code_t     found_code_q;
   key_code_t     scan_code_q;

   logic          hit;
   logic [CW-1:0] col_idx;
   key_code_t     hit_code;
   logic          last_dwell;
   logic          last_row;

   // Lowest-numbered active column wins (R7).
   always_comb begin
      hit     = 1'b0;
      col_idx = '0;
      for (int c = COLS - 1; c >= 0; c--) begin
         if (col_sync[c]) begin
            hit     = 1'b1;
            col_idx = CW'(c);
         end
      end
   end

   assign hit_code   = pack_code(int'(row_q), int'(col_idx));
   assign last_dwell = (dwell_q == DW'(DWELL - 1));
   assign last_row   = (row_q == RW'(ROWS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q        <= '0;
         dwell_q      <= '0;
         found_q      <= 1'b0;
         found_code_q <= '0;
         scan_code_q  <= '0;
      end else if (last_dwell) begin
         dwell_q <= '0;
         row_q   <= last_row ? '0 : RW'(row_q + 1'b1);
         if (last_row) begin
            if (found_q)  scan_code_q <= found_code_q;
            else if (hit) scan_code_q <= hit_code;
            else          scan_code_q <= '0;
            found_q      <= 1'b0;
            found_code_q <= '0;
         end else if (hit && !found_q) begin
            // First row to hit in this sweep is kept (R8).
            found_q      <= 1'b1;
            found_code_q <= hit_code;
         end
      end else begin
         dwell_q <= DW'(dwell_q + 1'b1);
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_drive[r] = (row_q == RW'(r));
   end

   assign scan_code = scan_code_q;

   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot(row_drive)); // R1
   AST_ROW_ROTATE: assert property (@(posedge clk) disable iff (rst)
      !$stable(row_drive) |-> row_drive == {$past(row_drive[ROWS-2:0]), $past(row_drive[ROWS-1])}); // R1
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
   import kpd_pkg::*;
#(
   parameter int DEBOUNCE = 1_000_000
) (
   input  logic      clk,
   input  logic      rst,
   input  key_code_t cand,
   output key_code_t held,
   output logic      strobe
);
   localparam int NW = (DEBOUNCE > 1) ? $clog2(DEBOUNCE) : 1;

   key_code_t     held_q;
   logic          strobe_q;
   logic [NW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q   <= '0;
         strobe_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         strobe_q <= 1'b0;
         if (cand != held_q) begin
            if (cnt_q == NW'(DEBOUNCE - 1)) begin
               held_q   <= cand;
               strobe_q <= 1'b1;
               cnt_q    <= '0;
            end else begin
               cnt_q <= NW'(cnt_q + 1'b1);
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign held   = held_q;
   assign strobe = strobe_q;

   AST_HELD_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      !$stable(held_q) |-> strobe_q); // R5
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      strobe_q |=> !strobe_q); // R6
   AST_STROBE_CHANGES: assert property (@(posedge clk) disable iff (rst)
      strobe_q |-> held_q != $past(held_q)); // R6
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
   import kpd_pkg::*;
#(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int SYNC_STAGES = 3,
   parameter int DWELL       = 16,
   parameter int DEBOUNCE    = 1_000_000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [COLS-1:0] col_in,
   output logic [ROWS-1:0] row_drive,
   output logic [7:0]      key_code,
   output logic            key_valid,
   output logic            key_strobe
);
   if (ROWS < 2 || ROWS > 15 || COLS < 1 || COLS > 15) begin : g_bad_dims
      $error("kpd_scanner: ROWS must be 2..15 and COLS 1..15");
   end
   if (DWELL < SYNC_STAGES + 2) begin : g_bad_dwell
      $error("kpd_scanner: DWELL must exceed synchroniser latency by 2");
   end
   if (DEBOUNCE < 2) begin : g_bad_deb
      $error("kpd_scanner: DEBOUNCE must be at least 2");
   end

   logic [COLS-1:0] col_sync;
   key_code_t       scan_code;
   key_code_t       held;

   kpd_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(col_in), .q(col_sync));

   kpd_scan #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) u_scan (
      .clk(clk), .rst(rst), .col_sync(col_sync),
      .row_drive(row_drive), .scan_code(scan_code));

   kpd_debounce #(.DEBOUNCE(DEBOUNCE)) u_deb (
      .clk(clk), .rst(rst), .cand(scan_code),
      .held(held), .strobe(key_strobe));

   assign key_code  = held;
   assign key_valid = |held;

   AST_CODE_FIELDS: assert property (@(posedge clk) disable iff (rst)
      key_valid |-> (key_code[7:4] >= 4'd1 && key_code[7:4] <= 4'(ROWS)
                  && key_code[3:0] >= 4'd1 && key_code[3:0] <= 4'(COLS))); // R2
endmodule

// File: tb/tb_kpd_scanner.sv
module tb_kpd_scanner;
   localparam int ROWS = 4, COLS = 4, SYNC = 3, DWELL = 8, DEB = 200;
   localparam int LIMIT = 2000;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [COLS-1:0] col_in;
   logic [ROWS-1:0] row_drive;
   logic [7:0]      key_code;
   logic            key_valid;
   logic            key_strobe;
   logic [15:0]     keys = '0; // bit (row-1)*4 + (col-1)

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   kpd_scanner #(.ROWS(ROWS), .COLS(COLS), .SYNC_STAGES(SYNC),
                 .DWELL(DWELL), .DEBOUNCE(DEB)) dut (
      .clk(clk), .rst(rst), .col_in(col_in), .row_drive(row_drive),
      .key_code(key_code), .key_valid(key_valid), .key_strobe(key_strobe));

   // Keypad matrix model: a held key ties its row line to its column line.
   always_comb begin
      col_in = '0;
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++)
            if (row_drive[r] && keys[r*4 + c]) col_in[c] = 1'b1;
   end

   // {key mask, expected code}
   localparam logic [23:0] VEC [6] = '{
      {16'h0001, 8'h11},   // R9 corner key
      {16'h0200, 8'h32},   // R2 row 3 col 2
      {16'h8000, 8'h44},   // R4 last row, last column
      {16'h0040, 8'h23},   // R4 row 2 col 3
      {16'h00A0, 8'h22},   // R7 row 2 cols 2 and 4
      {16'h0810, 8'h21}    // R8 row 3 col 4 and row 2 col 1
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_strobe(output int n, output bit got);
      n = 0; got = 1'b0;
      while (!got && n < LIMIT) begin
         @(negedge clk); n++;
         if (key_strobe) got = 1'b1;
      end
   endtask

   task automatic quiet(input int len, output int strobes);
      strobes = 0;
      repeat (len) begin
         @(negedge clk);
         if (key_strobe) strobes++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      int  n;
      int  s;
      bit  got;
      repeat (4) @(negedge clk);
      // R10 reset state
      check(row_drive == 4'b0001, "R10 row", row_drive, 1);
      check(key_code == 8'h00 && !key_valid && !key_strobe, "R10 code", key_code, 0);

      // R1 dwell and order
      rst = 1'b0;
      for (int r = 0; r < ROWS + 1; r++) begin
         n = 0;
         while (row_drive == 4'(1 << (r % ROWS)) && n < 100) begin
            n++; @(negedge clk);
         end
         check(n == DWELL, "R1 dwell", n, DWELL);
      end

      // Vector table
      for (int i = 0; i < 6; i++) begin
         keys = VEC[i][23:8];
         wait_strobe(n, got);
         check(got && n >= DEB && n <= DEB + 64, "R5 press latency", n, DEB);
         check(key_code == VEC[i][7:0], "R2 code", key_code, VEC[i][7:0]);
         check(key_valid, "R3 valid", key_valid, 1);
         @(negedge clk);
         check(!key_strobe, "R6 width", key_strobe, 0);
         keys = '0;
         wait_strobe(n, got);
         check(got && key_code == 8'h00 && !key_valid, "R6 release", key_code, 0);
      end

      // R5 short glitch ignored
      repeat (40) @(negedge clk);
      keys = 16'h0001;
      repeat (40) @(negedge clk);
      keys = '0;
      quiet(400, s);
      check(s == 0 && key_code == 8'h00, "R5 glitch", s, 0);

      // R11 key to key
      keys = 16'h0200;
      wait_strobe(n, got);
      check(got && key_code == 8'h32, "R11 first", key_code, 8'h32);
      keys = 16'h8000;
      wait_strobe(n, got);
      check(got && key_code == 8'h44, "R11 second", key_code, 8'h44);
      quiet(300, s);
      check(s == 0 && key_code == 8'h44, "R11 single change", s, 0);

      // R10 reset while a key is reported
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check(key_code == 8'h00 && !key_valid && row_drive == 4'b0001, "R10 mid reset", key_code, 0);
      keys = '0;
      @(negedge clk); rst = 1'b0;
      quiet(400, s);
      check(s == 0 && key_code == 8'h00, "R10 no stale count", s, 0);

      finish_run();
   end
endmodule